// File: doc/BRIEF.md
# Opcode-snooping fast output port

This block sits beside an 8-bit processor bus and watches opcode fetches. The processor has a family of one-byte, single-cycle no-operation opcodes whose low bits form a fixed key and whose high bits the core ignores. When the fetch strobe is high and the byte on the data bus carries the key, the block copies the ignored high bits into a small port register at the clock edge that closes that bus cycle. One instruction byte is therefore one port write, costing one bus cycle and no address space. Nothing is decoded from the address lines.

Two static configuration inputs shape the decode. The wide setting keys on bits [2:0] = 3'b011 and drives a 5-bit value. The narrow setting keys on bits [3:0] = 4'b0011 and drives a 4-bit value, with the top port bit held at zero. A filter can also be switched on so that the two bytes 8'hCB and 8'hDB never write the port. Some processor variants execute these two bytes as real instructions.

Top module: `opsnoop_port`

## Requirements
- R1: While rst_n is low at a rising clock edge, the port register is cleared, so port_q reads 5'b00000 after that edge.
- R2: With narrow_mode low, a cycle with fetch_strobe high and data_bus[2:0] = 3'b011 (and not blocked by R6) sets port_q to data_bus[7:3] at the closing rising edge. For example, 8'h03 gives 5'b00000 and 8'hFB gives 5'b11111.
- R3: With narrow_mode high, only bytes with data_bus[3:0] = 4'b0011 write the port, and port_q becomes {1'b0, data_bus[7:4]}. Bytes with low nibble 4'hB leave the port unchanged in this setting.
- R4: A cycle with fetch_strobe low never changes the port, whatever the data bus carries.
- R5: A cycle with fetch_strobe high whose byte does not carry the key for the current setting leaves the port unchanged.
- R6: With filter_en high, the bytes 8'hCB and 8'hDB do not write the port. With filter_en low, they write it as R2 says (5'b11001 and 5'b11011).
- R7: Qualifying fetches in consecutive cycles each update the port, so port_q can take a new value on every clock.
- R8: While narrow_mode is high, port_q[4] reads 0. This holds even if a wide write left that bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; a bus cycle closes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_strobe | input | 1 | High during an opcode-fetch bus cycle |
| data_bus | input | 8 | Processor data bus |
| narrow_mode | input | 1 | 0: 5-bit port keyed on 3'b011; 1: 4-bit port keyed on 4'b0011 |
| filter_en | input | 1 | 1: bytes 8'hCB and 8'hDB never write the port |
| port_q | output | 5 | Latched port value |

## Verification
The hardest case to reach from the ports is the overlap of conditions: a reserved byte fetched with the filter on, a low-nibble-B key byte in narrow mode, and a mode switch that hides a port bit already set. Purely random bytes rarely line these up with a stale port value that would show a wrong write. The stimulus therefore uses directed sequences that first load a distinctive value, then present each blocked byte with the strobe high. Biased random traffic follows, in which about half of the bytes are forced to carry the key and the mode and filter inputs toggle from cycle to cycle.

// File: rtl/opsnoop_pkg.sv
package opsnoop_pkg;
  localparam int DATA_W       = 8;
  localparam int FULL_KEY_W   = 3;
  localparam int NARROW_KEY_W = 4;
  localparam logic [FULL_KEY_W-1:0]   FULL_KEY   = 3'b011;
  localparam logic [NARROW_KEY_W-1:0] NARROW_KEY = 4'b0011;
  localparam int RESV_N = 2;
  localparam logic [7:0] RESV_LIST [RESV_N] = '{8'hCB, 8'hDB};
endpackage

// File: rtl/opsnoop_match.sv
module opsnoop_match #(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 3,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic [DATA_W-1:0]       data,
  output logic                    key_ok,
  output logic [DATA_W-KEY_W-1:0] payload
);
  localparam int PL_W = DATA_W - KEY_W;

  function automatic logic f_key(input logic [DATA_W-1:0] d);
    return d[KEY_W-1:0] == KEY;
  endfunction

  function automatic logic [PL_W-1:0] f_payload(input logic [DATA_W-1:0] d);
    return d[DATA_W-1:KEY_W];
  endfunction

  assign key_ok  = f_key(data);
  assign payload = f_payload(data);
endmodule

// File: rtl/opsnoop_guard.sv
module opsnoop_guard
  import opsnoop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              enable,
  output logic              blocked
);
  logic [RESV_N-1:0] eq;

  for (genvar i = 0; i < RESV_N; i++) begin : g_resv
    assign eq[i] = (data == DATA_W'(RESV_LIST[i]));
  end

  assign blocked = enable && (|eq);
endmodule

// File: rtl/opsnoop_capture.sv
module opsnoop_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/opsnoop_port.sv
module opsnoop_port
  import opsnoop_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int WKEY_W  = FULL_KEY_W,
  parameter int NKEY_W  = NARROW_KEY_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_strobe,
  input  logic [DW-1:0]        data_bus,
  input  logic                 narrow_mode,
  input  logic                 filter_en,
  output logic [DW-WKEY_W-1:0] port_q
);
  localparam int PORT_W   = DW - WKEY_W;
  localparam int NARROW_W = DW - NKEY_W;
  localparam int PAD_W    = PORT_W - NARROW_W;

  logic                wide_ok;
  logic                narrow_ok;
  logic [PORT_W-1:0]   wide_pl;
  logic [NARROW_W-1:0] narrow_pl;
  logic                resv_hit;
  logic                key_ok;
  logic                hit;
  logic [PORT_W-1:0]   next_val;
  logic [PORT_W-1:0]   stored;

  opsnoop_match #(.DATA_W(DW), .KEY_W(WKEY_W), .KEY(FULL_KEY)) u_wide (
    .data(data_bus), .key_ok(wide_ok), .payload(wide_pl)
  );

  opsnoop_match #(.DATA_W(DW), .KEY_W(NKEY_W), .KEY(NARROW_KEY)) u_narrow (
    .data(data_bus), .key_ok(narrow_ok), .payload(narrow_pl)
  );

  opsnoop_guard #(.DATA_W(DW)) u_guard (
    .data(data_bus), .enable(filter_en), .blocked(resv_hit)
  );

  assign key_ok   = narrow_mode ? narrow_ok : wide_ok;
  assign hit      = fetch_strobe && key_ok && !resv_hit;
  assign next_val = narrow_mode ? {{PAD_W{1'b0}}, narrow_pl} : wide_pl;

  opsnoop_capture #(.W(PORT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(hit), .d(next_val), .q(stored)
  );

  assign port_q = narrow_mode ? {{PAD_W{1'b0}}, stored[NARROW_W-1:0]} : stored;
endmodule

// File: rtl/opsnoop_port_chk.sv
module opsnoop_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_strobe,
  input logic [7:0] data_bus,
  input logic       narrow_mode,
  input logic       filter_en,
  input logic [4:0] port_q,
  input logic       hit
);
  logic resv;
  assign resv = filter_en && (data_bus == 8'hCB || data_bus == 8'hDB);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> port_q == 5'b00000); // R1

  AST_WIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe && !narrow_mode && data_bus[2:0] == 3'b011 && !resv)
    |=> (narrow_mode || port_q == $past(data_bus[7:3]))); // R2

  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe && narrow_mode && data_bus[3:0] == 4'b0011 && !resv)
    |=> port_q[3:0] == $past(data_bus[7:4])); // R3

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_strobe |=> (port_q == $past(port_q) || narrow_mode != $past(narrow_mode))); // R4

  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> fetch_strobe); // R4

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe && (narrow_mode ? data_bus[3:0] != 4'b0011 : data_bus[2:0] != 3'b011))
    |=> (port_q == $past(port_q) || narrow_mode != $past(narrow_mode))); // R5

  AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe && resv)
    |=> (port_q == $past(port_q) || narrow_mode != $past(narrow_mode))); // R6

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_mode |-> port_q[4] == 1'b0); // R8
endmodule

bind opsnoop_port opsnoop_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe), .data_bus(data_bus),
  .narrow_mode(narrow_mode), .filter_en(filter_en), .port_q(port_q), .hit(hit)
);

// File: tb/opsnoop_port_test.sv
`timescale 1ns/1ps
module opsnoop_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_strobe = 1'b0;
  logic [7:0] data_bus = 8'h00;
  logic       narrow_mode = 1'b0;
  logic       filter_en = 1'b0;
  logic [4:0] port_q;

  int checks = 0;
  int failures = 0;
  logic [4:0] model = 5'b00000;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opsnoop_port uut (
    .clk(clk), .rst_n(rst_n), .fetch_strobe(fetch_strobe), .data_bus(data_bus),
    .narrow_mode(narrow_mode), .filter_en(filter_en), .port_q(port_q)
  );

  function automatic logic [4:0] exp_next(input logic [4:0] cur, input logic rs,
      input logic s, input logic [7:0] d, input logic nm, input logic fe);
    if (!rs) return 5'b00000;
    if (!s) return cur;
    if (fe && (d == 8'hCB || d == 8'hDB)) return cur;
    if (nm) begin
      if (d[3:0] == 4'h3) return {1'b0, d[7:4]};
      return cur;
    end
    if (d[2:0] == 3'd3) return d[7:3];
    return cur;
  endfunction

  function automatic logic [4:0] view(input logic [4:0] st, input logic nm);
    return nm ? (st & 5'h0F) : st;
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    checks++;
    if (port_q !== exp) begin
      failures++;
      $display("FAIL %s: port_q=%b expected=%b", tag, port_q, exp);
    end
  endtask

  // called at a falling edge; applies inputs, lets one rising edge pass, checks
  task automatic step(input string tag, input logic rs, input logic s,
      input logic [7:0] d, input logic nm, input logic fe);
    rst_n = rs; fetch_strobe = s; data_bus = d; narrow_mode = nm; filter_en = fe;
    @(posedge clk);
    model = exp_next(model, rs, s, d, nm, fe);
    @(negedge clk);
    check(tag, view(model, nm));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 5'b00000);

    // R2 wide writes
    step("R2", 1, 1, 8'hFB, 0, 0);
    step("R2", 1, 1, 8'h03, 0, 0);
    step("R2", 1, 1, 8'h5B, 0, 0);
    // R4 no strobe, key-looking byte
    step("R4", 1, 0, 8'hF3, 0, 0);
    step("R4", 1, 0, 8'hFB, 1, 1);
    // R5 strobe with non-key bytes
    step("R5", 1, 1, 8'h07, 0, 0);
    step("R5", 1, 1, 8'hFF, 0, 1);
    // R3 narrow
    step("R3", 1, 1, 8'hA3, 1, 0);
    step("R3", 1, 1, 8'h5B, 1, 0);
    step("R3", 1, 1, 8'hEB, 1, 0);
    // R8 top bit hidden in narrow mode
    step("R8", 1, 1, 8'hFB, 0, 0);
    step("R8", 1, 0, 8'h00, 1, 0);
    step("R8", 1, 0, 8'h00, 0, 0);
    // R6 filter
    step("R6", 1, 1, 8'h13, 0, 1);
    step("R6", 1, 1, 8'hCB, 0, 1);
    step("R6", 1, 1, 8'hDB, 0, 1);
    step("R6", 1, 1, 8'hCB, 0, 0);
    step("R6", 1, 1, 8'h13, 0, 0);
    step("R6", 1, 1, 8'hDB, 0, 0);
    // R7 back-to-back
    for (int i = 0; i < 32; i++) step("R7", 1, 1, {i[4:0], 3'b011}, 0, 0);
    for (int i = 0; i < 16; i++) step("R7", 1, 1, {i[3:0], 4'b0011}, 1, 0);
    // R1 mid-run reset with a qualifying fetch
    step("R2", 1, 1, 8'hAB, 0, 0);
    step("R1", 0, 1, 8'hFB, 0, 0);
    step("R1", 1, 0, 8'h00, 0, 0);

    // biased random traffic
    for (int i = 0; i < 2000; i++) begin
      logic s, nm, fe;
      logic [7:0] d;
      s  = ($urandom % 4) != 0;
      nm = ($urandom % 5) == 0;
      fe = $urandom % 2;
      d  = 8'($urandom);
      if ($urandom % 2) d[2:0] = 3'b011;
      if (($urandom % 8) == 0) d = ($urandom % 2) ? 8'hCB : 8'hDB;
      step(s ? "R2" : "R4", (($urandom % 100) != 0), s, d, nm, fe);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule